// File: doc/BRIEF.md
# Per-Line Sprite Evaluation Engine

This block walks the 256-byte primary sprite table (64 entries of four bytes) during the first 256 dots of each visible line. It builds an 8-slot, 32-byte secondary list of the sprites whose vertical span covers the next line. Dots alternate between two jobs. An even dot reads one byte from the primary table. An odd dot either writes that byte into the secondary list or compares it against the line. The first 64 dots fill the secondary list with 0xFF. The remaining dots run the scan.

The block also keeps one marker bit per slot, which tells the pattern-fetch stage that a slot holds table entry 0. It raises a sticky overflow flag when a ninth sprite is found. The search for that ninth sprite deliberately copies a known scan fault: the entry index and the byte offset advance together, so the search can both miss real ninth sprites and flag false ones. The dot and line counters come from the surrounding timing generator. The primary table sits outside the block behind a combinational read port, and so does the secondary list behind a write port.

Top module: `spriteLineScan`

## Requirements
- R1: The primary table address is read only on even dots. The secondary write strobe `secWe` is asserted only on odd dots, and the write lands at the clock edge that ends that dot.
- R2: On an active line, odd dots 1..63 write 0xFF to secondary addresses 0..31 in ascending order (address = dot/2). The write on each slot's byte 3 also clears that slot's bit in `zeroMark`.
- R3: A byte Y is in range when the unsigned 9-bit difference (line − Y) is below the height. The height is 8 when `tallSprites`=0 and 16 when `tallSprites`=1.
- R4: The scan starts at dot 64 at table address 0 with slot 0. An in-range entry has its four bytes written to secondary addresses slot×4+0..3 on four successive odd dots, and the slot then advances. An out-of-range entry costs one odd dot and moves the address on by 4.
- R5: `zeroMark[s]` reads 1 after the scan only when slot s received table entry 0. That can only be slot 0.
- R6: Once all 64 entries have been scanned, the address returns to 0 and then grows by 4 on each following odd dot, with no further writes.
- R7: With all 8 slots full, each odd dot compares the byte at the current address as a Y value. On a miss, the next address is ((a+4) AND 0xFC) + ((a+1) AND 3). The search ends, aligned down to a multiple of 4, once that value is 5 or less.
- R8: A search hit sets `overflow`. The flag stays set over later lines and clears at dot 0 of the pre-render line.
- R9: The pre-render line runs the 0xFF clear but makes no range comparisons and no evaluation writes.
- R10: The processing of dot 255 returns the table address to 0, so `oamAddr` is 0 during dot 256 and during dot 64.
- R11: During reset, `overflow`, `zeroMark`, `secWe` and `oamAddr` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dot clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dot | input | 9 | Dot counter of the current line (0..340) |
| line | input | 9 | Line counter (0..239 visible, 261 pre-render) |
| tallSprites | input | 1 | Sprite height select: 0 = 8 lines, 1 = 16 lines |
| oamAddr | output | 8 | Read address into the primary sprite table |
| oamData | input | 8 | Byte read from the primary table at `oamAddr` |
| secWe | output | 1 | Secondary list write strobe |
| secAddr | output | 5 | Secondary list byte address (slot×4 + byte) |
| secData | output | 8 | Secondary list write data |
| zeroMark | output | 8 | Per-slot flag: slot holds table entry 0 |
| overflow | output | 1 | Sticky sprite-overflow flag |

## Verification
The scan is driven with a table that has no sprite on the line, which isolates the clear pass and the idle address stepping. It is also driven with scattered sprites whose Y lies just inside or just outside the 8- and 16-line windows, which exposes off-by-one range errors and a wrong height select. A table with exactly nine aligned sprites must flag overflow. Two further tables target the diagonal search: a true ninth sprite that the skewed walk steps past must not flag, and a stray attribute byte on the walk's path must flag. A pre-render line with sprites nominally in range confirms that only the clear runs there and that the flag drops.

// File: rtl/sprEvalPkg.sv
package sprEvalPkg;
  localparam int NUM_SLOTS   = 8;
  localparam int NUM_ENTRIES = 64;
  localparam int BYTES_PER   = 4;
  localparam int DATA_W      = 8;
  localparam int OAM_AW      = $clog2(NUM_ENTRIES * BYTES_PER);
  localparam int SEC_AW      = $clog2(NUM_SLOTS * BYTES_PER);
  localparam int SLOT_W      = $clog2(NUM_SLOTS);
  localparam int SLOTCNT_W   = $clog2(NUM_SLOTS + 1);
  localparam int CNT_W       = $clog2(NUM_ENTRIES + 1);
  localparam int WRAP_MAX    = BYTES_PER + 1;

  typedef enum logic [3:0] {
    PH_CLEAR, PH_SCAN, PH_COPY1, PH_COPY2, PH_COPY3,
    PH_OVF, PH_OVF1, PH_OVF2, PH_OVF3, PH_IDLE
  } phase_e;

  typedef enum logic [2:0] {
    AD_HOLD, AD_INC1, AD_INC4, AD_ZERO, AD_SKEW, AD_ALIGN
  } addrOp_e;

  typedef struct packed {
    logic                latch;
    logic                latchFill;
    addrOp_e             addrOp;
    logic                secFill;
    logic                markWr;
    logic [SLOT_W-1:0]   markSlot;
    logic                markVal;
    logic                ovfSet;
    logic                ovfClr;
  } evalCmd_t;
endpackage

// File: rtl/evalPath.sv
module evalPath
  import sprEvalPkg::*;
#(
  parameter int LINE_W  = 9,
  parameter int SHORT_H = 8,
  parameter int TALL_H  = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  evalCmd_t             cmd,
  input  logic [LINE_W-1:0]    line,
  input  logic                 tallSprites,
  input  logic [DATA_W-1:0]    oamData,
  output logic [OAM_AW-1:0]    oamAddr,
  output logic [DATA_W-1:0]    secData,
  output logic                 hit,
  output logic                 skewWrap,
  output logic [NUM_SLOTS-1:0] zeroMark,
  output logic                 overflow
);
  logic [DATA_W-1:0] fetchReg;
  logic [LINE_W-1:0] lineDiff;
  logic [OAM_AW-1:0] skewNext;
  logic [OAM_AW-1:0] alignNext;
  logic [OAM_AW-1:0] bump;

  // Range test: unsigned distance below the selected height
  always_comb begin
    lineDiff = line - LINE_W'(fetchReg);
    hit = lineDiff < (tallSprites ? LINE_W'(TALL_H) : LINE_W'(SHORT_H));
  end

  // Faulty overflow walk: entry index and byte offset advance together
  always_comb begin
    skewNext = {oamAddr[OAM_AW-1:2] + 1'b1, 2'b00} + OAM_AW'(oamAddr[1:0] + 2'd1);
    skewWrap = skewNext <= OAM_AW'(WRAP_MAX);
    bump = oamAddr + 1'b1;
    if (bump[1:0] == 2'b11) bump = bump + 1'b1;
    alignNext = {bump[OAM_AW-1:2], 2'b00};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fetchReg <= '1;
      oamAddr  <= '0;
      overflow <= 1'b0;
    end else begin
      if (cmd.latch) fetchReg <= cmd.latchFill ? '1 : oamData;
      unique case (cmd.addrOp)
        AD_INC1:  oamAddr <= oamAddr + 1'b1;
        AD_INC4:  oamAddr <= oamAddr + OAM_AW'(BYTES_PER);
        AD_ZERO:  oamAddr <= '0;
        AD_SKEW:  oamAddr <= skewWrap ? {skewNext[OAM_AW-1:2], 2'b00} : skewNext;
        AD_ALIGN: oamAddr <= alignNext;
        default:  oamAddr <= oamAddr;
      endcase
      if (cmd.ovfClr)      overflow <= 1'b0;
      else if (cmd.ovfSet) overflow <= 1'b1;
    end
  end

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_mark
    always_ff @(posedge clk) begin
      if (!rst_n) zeroMark[s] <= 1'b0;
      else if (cmd.markWr && cmd.markSlot == SLOT_W'(s)) zeroMark[s] <= cmd.markVal;
    end
  end

  assign secData = cmd.secFill ? '1 : fetchReg;

  // R8: a clear request wins over everything for the following cycle
  a_r8_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cmd.ovfClr |=> !overflow);
  // R5: marker set only for a single slot per write
  a_r5_one_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd.markWr && cmd.markVal) |=> (zeroMark[$past(cmd.markSlot)] == 1'b1));
endmodule

// File: rtl/evalCtrl.sv
module evalCtrl
  import sprEvalPkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DOT_W-1:0]  dot,
  input  logic [LINE_W-1:0] line,
  input  logic              hit,
  input  logic              skewWrap,
  output evalCmd_t          cmd,
  output logic              secWe,
  output logic [SEC_AW-1:0] secAddr
);
  localparam int CLEAR_END = NUM_SLOTS * BYTES_PER * 2 - 1;
  localparam int EVAL_END  = NUM_ENTRIES * BYTES_PER - 1;

  phase_e               phase;
  logic                 fetchMode;
  logic [SLOTCNT_W-1:0] slotCnt;
  logic [CNT_W-1:0]     count;
  logic                 preLine, inWindow, oddDot, lastEntry;
  logic [SLOT_W-1:0]    slotIdx;

  assign preLine   = line == LINE_W'(PRE_LINE);
  assign inWindow  = (line < LINE_W'(VIS_LINES) || preLine) && dot <= DOT_W'(EVAL_END);
  assign oddDot    = dot[0];
  assign slotIdx   = slotCnt[SLOT_W-1:0];
  assign lastEntry = count == CNT_W'(NUM_ENTRIES);

  always_comb begin
    cmd     = '0;
    secWe   = 1'b0;
    secAddr = '0;
    if (inWindow) begin
      if (!oddDot) begin
        cmd.latch     = 1'b1;
        cmd.latchFill = !fetchMode;
      end else begin
        unique case (phase)
          PH_CLEAR: if (dot <= DOT_W'(CLEAR_END)) begin
            secWe       = 1'b1;
            secAddr     = dot[SEC_AW:1];
            cmd.secFill = 1'b1;
            if (dot[2:1] == 2'b11) begin
              cmd.markWr   = 1'b1;
              cmd.markSlot = dot[SEC_AW:3];
              cmd.markVal  = 1'b0;
            end
          end
          PH_SCAN: if (!preLine) begin
            if (hit) begin
              cmd.addrOp   = AD_INC1;
              secWe        = 1'b1;
              secAddr      = {slotIdx, 2'b00};
              cmd.markWr   = 1'b1;
              cmd.markSlot = slotIdx;
              cmd.markVal  = count == '0;
            end else begin
              cmd.addrOp = (count == CNT_W'(NUM_ENTRIES - 1)) ? AD_ZERO : AD_INC4;
            end
          end
          PH_COPY1: begin
            cmd.addrOp = AD_INC1; secWe = 1'b1; secAddr = {slotIdx, 2'b01};
          end
          PH_COPY2: begin
            cmd.addrOp = AD_INC1; secWe = 1'b1; secAddr = {slotIdx, 2'b10};
          end
          PH_COPY3: begin
            cmd.addrOp = lastEntry ? AD_ZERO : AD_INC1;
            secWe = 1'b1; secAddr = {slotIdx, 2'b11};
          end
          PH_OVF: if (!preLine) begin
            if (hit) begin
              cmd.addrOp = AD_INC1;
              cmd.ovfSet = 1'b1;
            end else begin
              cmd.addrOp = AD_SKEW;
            end
          end
          PH_OVF1, PH_OVF2: cmd.addrOp = AD_INC1;
          PH_OVF3:          cmd.addrOp = AD_ALIGN;
          PH_IDLE:          cmd.addrOp = AD_INC4;
          default:          cmd.addrOp = AD_HOLD;
        endcase
      end
      if (preLine && dot == '0) cmd.ovfClr = 1'b1;
      if (dot == DOT_W'(EVAL_END)) cmd.addrOp = AD_ZERO;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase     <= PH_CLEAR;
      fetchMode <= 1'b0;
      slotCnt   <= '0;
      count     <= '0;
    end else if (inWindow) begin
      if (oddDot) begin
        unique case (phase)
          PH_SCAN: if (!preLine) begin
            count <= count + 1'b1;
            if (hit) phase <= PH_COPY1;
            else if (count == CNT_W'(NUM_ENTRIES - 1)) phase <= PH_IDLE;
          end
          PH_COPY1: phase <= PH_COPY2;
          PH_COPY2: phase <= PH_COPY3;
          PH_COPY3: begin
            slotCnt <= slotCnt + 1'b1;
            if (lastEntry) phase <= PH_IDLE;
            else if (slotCnt == SLOTCNT_W'(NUM_SLOTS - 1)) phase <= PH_OVF;
            else phase <= PH_SCAN;
          end
          PH_OVF: if (!preLine) begin
            if (hit) phase <= PH_OVF1;
            else if (skewWrap) phase <= PH_IDLE;
          end
          PH_OVF1: phase <= PH_OVF2;
          PH_OVF2: phase <= PH_OVF3;
          PH_OVF3: phase <= PH_IDLE;
          default: phase <= phase;
        endcase
      end
      if (dot == DOT_W'(CLEAR_END)) begin
        fetchMode <= 1'b1;
        phase     <= PH_SCAN;
        slotCnt   <= '0;
        count     <= '0;
      end
      if (dot == DOT_W'(EVAL_END)) begin
        fetchMode <= 1'b0;
        phase     <= PH_CLEAR;
        slotCnt   <= '0;
        count     <= '0;
      end
    end
  end

  // R6: never more entries scanned than the table holds
  a_r6_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_W'(NUM_ENTRIES));
  // R7: the overflow search only runs with every slot filled
  a_r7_search_full: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_OVF) |-> (slotCnt == SLOTCNT_W'(NUM_SLOTS)));
  // R4: copies never start beyond the last slot
  a_r4_slot_bound: assert property (@(posedge clk) disable iff (!rst_n)
    slotCnt <= SLOTCNT_W'(NUM_SLOTS));
endmodule

// File: rtl/spriteLineScan.sv
module spriteLineScan
  import sprEvalPkg::*;
#(
  parameter int DOT_W     = 9,
  parameter int LINE_W    = 9,
  parameter int VIS_LINES = 240,
  parameter int PRE_LINE  = 261,
  parameter int SHORT_H   = 8,
  parameter int TALL_H    = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [DOT_W-1:0]     dot,
  input  logic [LINE_W-1:0]    line,
  input  logic                 tallSprites,
  output logic [OAM_AW-1:0]    oamAddr,
  input  logic [DATA_W-1:0]    oamData,
  output logic                 secWe,
  output logic [SEC_AW-1:0]    secAddr,
  output logic [DATA_W-1:0]    secData,
  output logic [NUM_SLOTS-1:0] zeroMark,
  output logic                 overflow
);
  localparam int CLEAR_END = NUM_SLOTS * BYTES_PER * 2 - 1;
  localparam int EVAL_END  = NUM_ENTRIES * BYTES_PER - 1;

  evalCmd_t cmd;
  logic     hit, skewWrap;

  evalCtrl #(
    .DOT_W(DOT_W), .LINE_W(LINE_W), .VIS_LINES(VIS_LINES), .PRE_LINE(PRE_LINE)
  ) i_ctrl (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .hit(hit),
    .skewWrap(skewWrap), .cmd(cmd), .secWe(secWe), .secAddr(secAddr)
  );

  evalPath #(
    .LINE_W(LINE_W), .SHORT_H(SHORT_H), .TALL_H(TALL_H)
  ) i_path (
    .clk(clk), .rst_n(rst_n), .cmd(cmd), .line(line), .tallSprites(tallSprites),
    .oamData(oamData), .oamAddr(oamAddr), .secData(secData), .hit(hit),
    .skewWrap(skewWrap), .zeroMark(zeroMark), .overflow(overflow)
  );

  a_r1_write_odd: assert property (@(posedge clk) disable iff (!rst_n)
    secWe |-> dot[0]);
  a_r2_clear_ff: assert property (@(posedge clk) disable iff (!rst_n)
    (secWe && dot <= DOT_W'(CLEAR_END)) |-> (secData == '1));
  a_r9_pre_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LINE_W'(PRE_LINE) && dot > DOT_W'(CLEAR_END)) |-> !secWe);
  a_r10_addr_home: assert property (@(posedge clk) disable iff (!rst_n)
    ((line < LINE_W'(VIS_LINES) || line == LINE_W'(PRE_LINE)) && dot == DOT_W'(EVAL_END))
      |=> (oamAddr == '0));
  a_r8_pre_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (line == LINE_W'(PRE_LINE) && dot == '0) |=> !overflow);
endmodule

// File: tb/test_spriteLineScan.sv
module test_spriteLineScan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [8:0] dot = '0;
  logic [8:0] line = '0;
  logic       tallSprites = 1'b0;
  logic [7:0] oamAddr, oamData, secData, zeroMark;
  logic [4:0] secAddr;
  logic       secWe, overflow;
  logic [7:0] prim [256];
  logic [12:0] expQ [$];
  int compared = 0;
  int mismatched = 0;
  bit ovfExp = 1'b0;
  bit zeroExp = 1'b0;

  always #5 clk = ~clk;
  assign oamData = prim[oamAddr];

  spriteLineScan i_spriteLineScan (
    .clk(clk), .rst_n(rst_n), .dot(dot), .line(line), .tallSprites(tallSprites),
    .oamAddr(oamAddr), .oamData(oamData), .secWe(secWe), .secAddr(secAddr),
    .secData(secData), .zeroMark(zeroMark), .overflow(overflow)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit inRange(input int l, input logic [7:0] y, input bit t);
    return ((l - int'(y)) & 511) < (t ? 16 : 8);
  endfunction

  // Monitor: pop expected writes as the design issues them
  always @(negedge clk) begin
    if (rst_n && secWe) begin
      check("R1 write on odd dot", 32'(dot[0]), 32'd1);
      if (expQ.size() == 0) begin
        check("R2/R4 unexpected write", {19'd0, secAddr, secData}, 32'h1FFF);
      end else begin
        logic [12:0] e;
        e = expQ.pop_front();
        check("R2/R4 write addr/data", {19'd0, secAddr, secData}, {19'd0, e});
      end
    end
  end

  task automatic fillTable(input logic [7:0] v);
    for (int i = 0; i < 256; i++) prim[i] = v;
  endtask

  // Driver: build the expected write stream, then run the dots of one line
  task automatic runLine(input int l, input bit t, input bit pre, input string tag,
                         input bit idleChk);
    int slots, budget, nextE;
    logic [7:0] a, n;
    tallSprites = t;
    for (int i = 0; i < 32; i++) expQ.push_back({5'(i), 8'hFF});
    zeroExp = 1'b0;
    if (pre) ovfExp = 1'b0;
    else begin
      slots = 0; budget = 0; nextE = 64;
      for (int e = 0; e < 64; e++) begin
        if (inRange(l, prim[4*e], t)) begin
          for (int k = 0; k < 4; k++) expQ.push_back({5'(slots*4+k), prim[4*e+k]});
          if (e == 0) zeroExp = 1'b1;
          slots++; budget += 4;
          if (slots == 8) begin nextE = e + 1; break; end
        end else budget += 1;
      end
      if (slots == 8 && nextE < 64) begin
        a = 8'(4 * nextE);
        while (budget < 96) begin
          budget++;
          if (inRange(l, prim[a], t)) begin ovfExp = 1'b1; break; end
          n = 8'({a[7:2] + 6'd1, 2'b00}) + 8'({6'd0, a[1:0] + 2'd1});
          if (n <= 8'd5) break;
          a = n;
        end
      end
    end
    for (int d = 0; d < 341; d++) begin
      dot = 9'(d);
      line = 9'(l);
      @(negedge clk);
      if (d == 1 && pre) check("R8 flag cleared on pre-render", 32'(overflow), 32'd0);
      if (d == 64) check("R10 address 0 at scan start", 32'(oamAddr), 32'd0);
      if (d == 196 && idleChk) check("R6 idle steps by 4", 32'(oamAddr), 32'd8);
      if (d == 256) begin
        check({tag, " pending writes"}, 32'(expQ.size()), 32'd0);
        check("R5 zero marker", 32'(zeroMark), 32'(zeroExp));
        check({tag, " overflow"}, 32'(overflow), 32'(ovfExp));
        check("R10 address 0 after dot 255", 32'(oamAddr), 32'd0);
      end
      @(posedge clk); #1;
    end
    expQ.delete();
  endtask

  initial begin
    fork
      begin
        repeat (60000) @(posedge clk);
        compared++; mismatched++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none
    fillTable(8'hF8);
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R11 overflow in reset", 32'(overflow), 32'd0);
    check("R11 zeroMark in reset", 32'(zeroMark), 32'd0);
    check("R11 secWe in reset", 32'(secWe), 32'd0);
    check("R11 oamAddr in reset", 32'(oamAddr), 32'd0);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // No sprite on the line: clear only, idle stepping
    runLine(10, 1'b0, 1'b0, "R6", 1'b1);

    // Short height, edges of the 8-line window, entry 0 present
    fillTable(8'hF8);
    prim[0] = 8'd50; prim[1] = 8'h11; prim[2] = 8'h22; prim[3] = 8'h33;
    prim[20] = 8'd43; prim[21] = 8'h44; prim[22] = 8'h55; prim[23] = 8'h66;
    prim[24] = 8'd42; prim[28] = 8'd51;
    runLine(50, 1'b0, 1'b0, "R3", 1'b0);

    // Tall height: entry 0 absent, 15 inside, 16 outside
    prim[0] = 8'hF8;
    prim[32] = 8'd35; prim[33] = 8'h77; prim[34] = 8'h88; prim[35] = 8'h99;
    prim[36] = 8'd34;
    runLine(50, 1'b1, 1'b0, "R3", 1'b0);
    runLine(50, 1'b0, 1'b0, "R4", 1'b0);

    // Nine aligned sprites: true overflow
    fillTable(8'hF8);
    for (int e = 0; e < 9; e++) begin
      prim[4*e] = 8'd100; prim[4*e+1] = 8'(e); prim[4*e+2] = 8'(e + 8'h40); prim[4*e+3] = 8'(e * 9);
    end
    runLine(100, 1'b0, 1'b0, "R8", 1'b0);
    fillTable(8'hF8);
    runLine(101, 1'b0, 1'b0, "R8", 1'b0);
    for (int e = 0; e < 64; e++) prim[4*e] = 8'd255;
    runLine(261, 1'b0, 1'b1, "R9", 1'b0);

    // Real ninth sprite stepped over by the skewed walk
    fillTable(8'hF8);
    for (int e = 0; e < 8; e++) prim[4*e] = 8'd120;
    prim[36] = 8'd120;
    runLine(120, 1'b0, 1'b0, "R7", 1'b0);

    // Stray attribute byte on the walk's path: false overflow
    fillTable(8'hF8);
    for (int e = 0; e < 8; e++) prim[4*e] = 8'd130;
    prim[42] = 8'd130;
    runLine(130, 1'b0, 1'b0, "R7", 1'b0);
    runLine(261, 1'b0, 1'b1, "R9", 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule